// File: doc/BRIEF.md
# Ternary Flow Classifier

This block sorts packets into flows by matching a 112-bit header key against a small table of ternary rules. Each rule has a value, a care mask and a 16-bit flow number. A key bit counts only where the rule's mask bit is set. Every rule is checked in the same cycle, and the lowest-numbered rule that matches supplies the flow number.

A host loads rules one at a time through a plain write port. Lookups enter on a valid/ready stream and leave, one cycle later, on a second valid/ready stream. The upstream side sees `lk_ready` high whenever the result register is empty or is being drained in the same cycle. When the consumer holds `res_ready` low while a result is pending, the result stays frozen and no new key is accepted. With `res_ready` tied high, the block takes a key every cycle.

The key is packed from high bits to low bits as follows: content-match bits [111:104], source IPv4 address [103:72], destination IPv4 address [71:40], source port [39:24], destination port [23:8] and protocol [7:0]. To express an address prefix of length n, set the top n care bits of that address field. To make a field don't-care, clear its whole mask.

Top module: `tcam_flow_classifier`

## Requirements
- R1: After reset every rule is empty, no result is pending (`res_valid`=0), `lk_ready`=1, and any lookup misses.
- R2: For each bit, a care bit of 1 requires the key bit to equal the value bit, and a care bit of 0 makes that key bit irrelevant. This covers a /16 address prefix and an all-zero mask on a port field.
- R3: A rule matches only when all six fields match at the same time. A mismatch in any cared-for field, such as the destination address or the destination port, rejects the rule.
- R4: A rule with value {01,80FC0000,8D8E0000,0000,0050,06} and mask {01,FFFF0000,FFFF0000,0000,FFFF,FF} matches the key {03,80FC0505,8D8E0202,1000,0050,06}. Fields are listed in the key layout order.
- R5: When more than one rule matches, the rule with the lowest index supplies `res_flow`.
- R6: When no rule matches, the result is `res_hit`=0 and `res_flow`=0.
- R7: A write with `wr_live`=0 marks the indexed rule empty. An empty rule never matches, even with an all-zero mask.
- R8: A lookup accepted on the same clock edge as a write sees the old table. A lookup accepted on the next edge sees the new rule.
- R9: A key accepted on one clock edge produces `res_valid`=1 with its result after that edge. If no key is accepted while the result is drained, `res_valid` drops.
- R10: While `res_valid`=1 and `res_ready`=0, `lk_ready` is 0 and `res_hit`/`res_flow` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Rule write strobe |
| wr_idx | input | 3 | Rule index to write |
| wr_live | input | 1 | 1 fills the rule, 0 empties it |
| wr_value | input | 112 | Rule value |
| wr_care | input | 112 | Rule care mask (1 = compare) |
| wr_flow | input | 16 | Rule flow number |
| lk_valid | input | 1 | Key valid |
| lk_ready | output | 1 | Key accepted when high together with lk_valid |
| lk_key | input | 112 | Packed header key |
| res_valid | output | 1 | Result pending |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | Some rule matched |
| res_flow | output | 16 | Flow number of the winning rule, 0 on a miss |

## Verification
Each lookup result appears one clock edge after the key is accepted. The bench drives inputs on the falling edge and reads outputs just after the rising edge that registers the result. A table write is visible one edge after it is made, so the bench pairs a write with a lookup on the same edge and checks for a miss, then checks for a hit on the edge that follows. Back-pressure is tested by holding `res_ready` low for an extra edge. The bench then confirms that the frozen result is still present and that the waiting key lands on the first edge after `res_ready` rises.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int KEY_W      = 112;
  localparam int FLOW_W     = 16;
  localparam int NUM_FIELDS = 6;

  // Field order: 0 content, 1 src addr, 2 dst addr, 3 src port, 4 dst port, 5 protocol
  function automatic int field_lsb(input int f);
    case (f)
      0:       return 104;
      1:       return 72;
      2:       return 40;
      3:       return 24;
      4:       return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int field_width(input int f);
    case (f)
      0:       return 8;
      1:       return 32;
      2:       return 32;
      3:       return 16;
      4:       return 16;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/tcam_rule_store.sv
module tcam_rule_store #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = tcam_pkg::KEY_W,
  parameter int FLOW_W  = tcam_pkg::FLOW_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic                     wr_live,
  input  logic [KEY_W-1:0]         wr_value,
  input  logic [KEY_W-1:0]         wr_care,
  input  logic [FLOW_W-1:0]        wr_flow,
  output logic [ENTRIES-1:0]       live,
  output logic [KEY_W-1:0]         value [ENTRIES],
  output logic [KEY_W-1:0]         care  [ENTRIES],
  output logic [FLOW_W-1:0]        flow  [ENTRIES]
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_rule
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live[i]  <= 1'b0;
        value[i] <= '0;
        care[i]  <= '0;
        flow[i]  <= '0;
      end else if (sel) begin
        live[i]  <= wr_live;
        value[i] <= wr_value;
        care[i]  <= wr_care;
        flow[i]  <= wr_flow;
      end
    end
  end

  // R7: an emptying write leaves the indexed rule empty
  assert_empty_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_live) |=> !live[$past(wr_idx)]);
endmodule

// File: rtl/tcam_match_array.sv
module tcam_match_array #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = tcam_pkg::KEY_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [KEY_W-1:0]   key,
  input  logic [ENTRIES-1:0] live,
  input  logic [KEY_W-1:0]   value [ENTRIES],
  input  logic [KEY_W-1:0]   care  [ENTRIES],
  output logic [ENTRIES-1:0] match
);
  import tcam_pkg::*;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [NUM_FIELDS-1:0] field_ok;
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
      localparam int LSB = field_lsb(f);
      localparam int W   = field_width(f);
      assign field_ok[f] =
        ((key[LSB +: W] ^ value[i][LSB +: W]) & care[i][LSB +: W]) == '0;
    end
    assign match[i] = live[i] && (&field_ok);
  end

  // R7: empty rules never raise a match
  assert_empty_no_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (match & ~live) == '0);
endmodule

// File: rtl/tcam_prio_pick.sv
module tcam_prio_pick #(
  parameter int ENTRIES = 8,
  parameter int FLOW_W  = tcam_pkg::FLOW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] match,
  input  logic [FLOW_W-1:0]  flow [ENTRIES],
  output logic               any,
  output logic [FLOW_W-1:0]  win_flow
);
  logic [ENTRIES-1:0] grant;
  logic [ENTRIES:0]   taken;
  logic [FLOW_W-1:0]  part [ENTRIES+1];

  assign taken[0] = 1'b0;
  assign part[0]  = '0;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_pick
    assign grant[i]    = match[i] && !taken[i];
    assign taken[i+1]  = taken[i] || match[i];
    assign part[i+1]   = part[i] | (grant[i] ? flow[i] : '0);
  end
  assign any      = taken[ENTRIES];
  assign win_flow = part[ENTRIES];

  // R5: at most one winner, and it is one of the matching rules
  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~match) == '0));
endmodule

// File: rtl/tcam_flow_classifier.sv
module tcam_flow_classifier #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = tcam_pkg::KEY_W,
  parameter int FLOW_W  = tcam_pkg::FLOW_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_live,
  input  logic [KEY_W-1:0]  wr_value,
  input  logic [KEY_W-1:0]  wr_care,
  input  logic [FLOW_W-1:0] wr_flow,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [KEY_W-1:0]  lk_key,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [FLOW_W-1:0] res_flow
);
  logic [ENTRIES-1:0] live;
  logic [KEY_W-1:0]   value [ENTRIES];
  logic [KEY_W-1:0]   care  [ENTRIES];
  logic [FLOW_W-1:0]  flow  [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic               any;
  logic [FLOW_W-1:0]  win_flow;
  logic               take;

  tcam_rule_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .FLOW_W(FLOW_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_live(wr_live),
    .wr_value(wr_value), .wr_care(wr_care), .wr_flow(wr_flow),
    .live(live), .value(value), .care(care), .flow(flow));

  tcam_match_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_match (
    .clk(clk), .rst_n(rst_n), .key(lk_key), .live(live),
    .value(value), .care(care), .match(match));

  tcam_prio_pick #(.ENTRIES(ENTRIES), .FLOW_W(FLOW_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .match(match), .flow(flow),
    .any(any), .win_flow(win_flow));

  assign lk_ready = !res_valid || res_ready;
  assign take     = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_flow  <= '0;
    end else if (lk_ready) begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_hit  <= any;
        res_flow <= win_flow;
      end
    end
  end

  // R9: an accepted key always yields a pending result on the next cycle
  assert_accept_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> res_valid);

  // R10: a stalled result stays put
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_flow)));

  // R6: a miss reports flow zero
  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_flow == '0));
endmodule

// File: tb/tb_tcam_flow_classifier.sv
module tb_tcam_flow_classifier;
  localparam int KW = 112;
  localparam int FW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_live = 1'b0;
  logic [2:0]    wr_idx = '0;
  logic [KW-1:0] wr_value = '0, wr_care = '0;
  logic [FW-1:0] wr_flow = '0;
  logic          lk_valid = 1'b0, lk_ready;
  logic [KW-1:0] lk_key = '0;
  logic          res_valid, res_ready = 1'b1, res_hit;
  logic [FW-1:0] res_flow;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tcam_flow_classifier dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_live(wr_live),
    .wr_value(wr_value), .wr_care(wr_care), .wr_flow(wr_flow),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_key(lk_key),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit), .res_flow(res_flow));

  typedef struct packed {
    logic [KW-1:0] key;
    logic          hit;
    logic [FW-1:0] flow;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    // R4 R5: worked key hits rule 0 ahead of rule 1
    '{{8'h03, 32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06}, 1'b1, 16'h00A1},
    // R3: dst port differs, rule 0 rejected, rule 1 catches protocol
    '{{8'h03, 32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0051, 8'h06}, 1'b1, 16'h00B2},
    // exact source address rule
    '{{8'h00, 32'h0A000001, 32'h00000000, 16'h0000, 16'h0000, 8'h11}, 1'b1, 16'h00C3},
    // R6 R7: nothing matches; empty all-wild rule 3 ignored
    '{{8'h00, 32'h0A000002, 32'h00000000, 16'h0000, 16'h0000, 8'h11}, 1'b0, 16'h0000},
    // R2: single content bit cared
    '{{8'h81, 32'h01010101, 32'h00000000, 16'h0000, 16'h0000, 8'h11}, 1'b1, 16'h00E5},
    // R2: /16 prefix fails in upper half
    '{{8'h03, 32'h80FD0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06}, 1'b1, 16'h00B2},
    // R2 R3: don't-care bits vary freely; then dst address breaks it below
    '{{8'h01, 32'h80FC1234, 32'h8D8E9999, 16'hFFFF, 16'h0050, 8'h06}, 1'b1, 16'h00A1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_rule(input int idx, input logic live, input logic [KW-1:0] v,
                            input logic [KW-1:0] c, input logic [FW-1:0] f);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_live = live;
    wr_value = v; wr_care = c; wr_flow = f;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // present one key, sample just after the registering edge
  task automatic lookup(input logic [KW-1:0] k, output logic hit, output logic [FW-1:0] fl,
                        output logic vld);
    @(negedge clk);
    lk_valid = 1'b1; lk_key = k;
    @(posedge clk); #1;
    hit = res_hit; fl = res_flow; vld = res_valid;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic h, v;
    logic [FW-1:0] f;
    logic [KW-1:0] kx;
    kx = {8'h00, 32'h0B0B0B0B, 32'h0, 16'h0, 16'h0, 8'h33};

    repeat (3) @(posedge clk);
    #1;
    check("R1 res_valid in reset", 32'(res_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 res_valid after reset", 32'(res_valid), 0);
    check("R1 lk_ready after reset", 32'(lk_ready), 1);
    lookup(VECS[0].key, h, f, v);
    check("R1 empty table miss", 32'(h), 0);
    check("R1 empty table flow", 32'(f), 0);

    write_rule(0, 1'b1, {8'h01, 32'h80FC0000, 32'h8D8E0000, 16'h0000, 16'h0050, 8'h06},
                        {8'h01, 32'hFFFF0000, 32'hFFFF0000, 16'h0000, 16'hFFFF, 8'hFF}, 16'h00A1);
    write_rule(1, 1'b1, {104'h0, 8'h06}, {104'h0, 8'hFF}, 16'h00B2);
    write_rule(2, 1'b1, {8'h0, 32'h0A000001, 72'h0}, {8'h0, 32'hFFFFFFFF, 72'h0}, 16'h00C3);
    write_rule(3, 1'b0, '0, '0, 16'h00D4);
    write_rule(4, 1'b1, {8'h80, 104'h0}, {8'h80, 104'h0}, 16'h00E5);

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].key, h, f, v);
      check($sformatf("vector %0d valid (R9)", i), 32'(v), 1);
      check($sformatf("vector %0d hit (R2-related)", i), 32'(h), 32'(VECS[i].hit));
      check($sformatf("vector %0d flow (R5/R6)", i), 32'(f), 32'(VECS[i].flow));
    end

    // R3: destination address outside /16 rejects rule 0 and nothing else fits
    lookup({8'h03, 32'h80FC0505, 32'h8D8F0202, 16'h1000, 16'h0050, 8'h11}, h, f, v);
    check("R3 dst addr mismatch miss", 32'(h), 0);

    // R9: result drains when no key follows
    @(posedge clk); #1;
    check("R9 res_valid drops", 32'(res_valid), 0);

    // R8: write and lookup on the same edge, then the next edge
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd5; wr_live = 1'b1; wr_value = kx; wr_care = '1; wr_flow = 16'h00F6;
    lk_valid = 1'b1; lk_key = kx;
    @(posedge clk); #1;
    check("R8 same-edge lookup sees old table", 32'(res_hit), 0);
    @(negedge clk); wr_en = 1'b0;
    @(posedge clk); #1;
    check("R8 next-edge lookup hits", 32'(res_hit), 1);
    check("R8 next-edge flow", 32'(res_flow), 32'h00F6);
    @(negedge clk); lk_valid = 1'b0;

    // R7: emptying the rule removes the match
    write_rule(5, 1'b0, kx, '1, 16'h00F6);
    lookup(kx, h, f, v);
    check("R7 emptied rule misses", 32'(h), 0);
    check("R6 miss flow zero", 32'(f), 0);

    // R10: back-pressure
    @(negedge clk);
    res_ready = 1'b0; lk_valid = 1'b1; lk_key = VECS[0].key;
    @(posedge clk); #1;
    check("R10 first result flow", 32'(res_flow), 32'h00A1);
    check("R10 lk_ready low while stalled", 32'(lk_ready), 0);
    @(negedge clk); lk_key = VECS[2].key;
    @(posedge clk); #1;
    check("R10 result held", 32'(res_flow), 32'h00A1);
    check("R10 still valid", 32'(res_valid), 1);
    @(negedge clk); res_ready = 1'b1;
    @(posedge clk); #1;
    check("R10 waiting key lands", 32'(res_flow), 32'h00C3);
    @(negedge clk); lk_valid = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule